// File: doc/BRIEF.md
# ATM Cell Receive Port

This block sits on the ATM-layer side of a byte-wide receive link from a PHY device. It requests bytes with an active-low enable, samples an 8-bit data bus and a start-of-cell strobe on the rising clock edge, and finds cell boundaries from the strobe. Each cell is `CELL_BYTES` bytes long (53 by default). Accepted bytes leave on a valid/ready byte stream that carries start and end markers. A one-cycle abort pulse reports a cell that was cut short by an early start-of-cell.

One status input from the PHY has two meanings, selected by the `cell_mode` pin. With `cell_mode` = 0 (per-byte handshake) the input is an active-low empty flag: a requested byte counts only if the flag is high in the cycle the byte is on the bus. With `cell_mode` = 1 (per-cell handshake) the input means "a further cell is available". The block opens a new cell grant only after it has seen this flag high. Once a grant is open it takes all `CELL_BYTES` bytes without looking at the flag again.

Back-pressure rules on the output stream: a beat transfers on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the beat and its markers are held unchanged. A byte already requested from the PHY when the output stalls is parked in a one-entry skid register. The enable is withdrawn so that nothing is lost. The PHY enable depends combinationally on `out_ready`. `cell_mode` may change only while no cell is in progress and no bytes are in flight.

Top module: `atm_rx_port`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `phy_en_n` is 1, `out_valid` is 0 and `cell_abort` is 0.
- R2: With `cell_mode` = 0, a byte is taken only in the cycle after one in which `phy_en_n` was 0, and only if `phy_stat` is 1 in that cycle. A byte present while `phy_stat` is 0 is ignored, even if `phy_soc` is 1.
- R3: Taken bytes appear on `out_data` in bus order. `out_sop` = 1 marks the byte taken with `phy_soc` = 1. `out_eop` = 1 marks the `CELL_BYTES`-th byte of a cell. No beat has both markers set.
- R4: With `cell_mode` = 1, once a cell grant has begun, all `CELL_BYTES` bytes of the cell are taken whatever the value of `phy_stat`.
- R5: With `cell_mode` = 1, `phy_enable` is not asserted for a new cell until `phy_stat` = 1 has been sampled after the previous grant began. With no cell ever offered, `phy_en_n` stays 1.
- R6: A byte taken with `phy_soc` = 1 while a cell is only partly received raises `cell_abort` for exactly one cycle per such byte. That byte begins a new cell, marked with `out_sop`.
- R7: Bytes taken while no cell is in progress and with `phy_soc` = 0 are discarded and produce no output beat.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values. No taken byte is lost or duplicated under any pattern of `out_ready`.
- R9: At most one requested byte is held beyond the output register. While the output is stalled, `phy_en_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the link and the stream (it also serves as the receive clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_mode | input | 1 | 0 = per-byte handshake, 1 = per-cell handshake |
| phy_data | input | 8 | Receive byte from the PHY |
| phy_soc | input | 1 | High with the first byte of a cell |
| phy_stat | input | 1 | Empty flag (active low) in per-byte mode, cell-available flag in per-cell mode |
| phy_en_n | output | 1 | Active-low request: a byte may be sent next cycle |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Beat is the first byte of a cell |
| out_eop | output | 1 | Beat is the last byte of a cell |
| cell_abort | output | 1 | One-cycle pulse: a partial cell was cut off by a new start |

## Verification
The hardest case to reach from the ports is a per-cell-mode grant in which the cell-available flag drops in the middle of the last queued cell while the output stalls at random. The block must still finish that cell and must not open another one. The bench's PHY model derives the flag each cycle from how many queued bytes lie beyond the current cell. It pops a byte only for a recorded grant and reports any grant it cannot serve. A pseudo-random `out_ready` pattern keeps the skid register filling and draining throughout. Per-byte runs interleave invalid slots that carry a start strobe, orphan bytes, a 20-byte truncated cell and a one-byte cell.

// File: rtl/atm_rx_pkg.sv
`timescale 1ns/1ps
package atm_rx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              eop;
  } rx_beat_t;
endpackage

// File: rtl/atm_rx_req.sv
`timescale 1ns/1ps
// Request generator: decides when to ask the PHY for a byte and
// qualifies the byte that arrives one cycle later.
module atm_rx_req #(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_mode,
  input  logic phy_stat,
  input  logic space,
  output logic req,
  output logic byte_due,
  output logic stat_ok
);
  localparam int unsigned CW = $clog2(CELL_BYTES + 1);

  logic          run;
  logic          due_q;
  logic          clav_seen;
  logic [CW-1:0] grant_left;
  logic          grant_start;
  logic          grant_cont;

  // per-cell mode: open a grant only after the flag was seen high
  assign grant_start = cell_mode && run && space && (grant_left == '0) && clav_seen;
  assign grant_cont  = cell_mode && run && space && (grant_left != '0);
  assign req         = cell_mode ? (grant_start || grant_cont) : (run && space);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      due_q      <= 1'b0;
      clav_seen  <= 1'b0;
      grant_left <= '0;
    end else begin
      run   <= 1'b1;
      due_q <= req;
      if (!cell_mode) begin
        grant_left <= '0;
        clav_seen  <= 1'b0;
      end else begin
        if (grant_start)     grant_left <= CW'(CELL_BYTES - 1);
        else if (grant_cont) grant_left <= grant_left - 1'b1;
        if (grant_start)     clav_seen <= 1'b0;
        else if (phy_stat)   clav_seen <= 1'b1;
      end
    end
  end

  assign byte_due = due_q;
  // per-byte mode: status is an active-low empty flag for this byte
  assign stat_ok  = cell_mode || phy_stat;
endmodule

// File: rtl/atm_rx_framer.sv
`timescale 1ns/1ps
// Cell delineation: marks start/end, drops orphans, flags truncation.
module atm_rx_framer
  import atm_rx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] data,
  input  logic              soc,
  output logic              beat_valid,
  output rx_beat_t          beat,
  output logic              abort
);
  localparam int unsigned CW = $clog2(CELL_BYTES + 1);

  logic [CW-1:0] pos;
  logic          in_cell;
  logic          at_last;

  assign in_cell = (pos != '0);
  assign at_last = (pos == CW'(CELL_BYTES - 1));

  always_comb begin
    beat_valid = 1'b0;
    beat.data  = data;
    beat.sop   = 1'b0;
    beat.eop   = 1'b0;
    if (accept && soc) begin
      beat_valid = 1'b1;
      beat.sop   = 1'b1;
    end else if (accept && in_cell) begin
      beat_valid = 1'b1;
      beat.eop   = at_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      abort <= 1'b0;
    end else begin
      abort <= accept && soc && in_cell;
      if (accept) begin
        if (soc)          pos <= CW'(1);
        else if (in_cell) pos <= at_last ? '0 : pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/atm_rx_skid.sv
`timescale 1ns/1ps
// Output register plus one-entry skid; reports room for a new request.
module atm_rx_skid
  import atm_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  rx_beat_t in_beat,
  input  logic     out_ready,
  output logic     out_valid,
  output rx_beat_t out_beat,
  output logic     space
);
  logic     skid_v;
  rx_beat_t skid_q;
  logic     drain;

  assign drain = !out_valid || out_ready;
  assign space = !skid_v && drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      skid_v    <= 1'b0;
      out_beat  <= '0;
      skid_q    <= '0;
    end else if (drain) begin
      if (skid_v) begin
        out_beat  <= skid_q;
        out_valid <= 1'b1;
        if (in_valid) skid_q <= in_beat;
        else          skid_v <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_beat <= in_beat;
      end
    end else if (in_valid) begin
      skid_q <= in_beat;
      skid_v <= 1'b1;
    end
  end
endmodule

// File: rtl/atm_rx_port.sv
`timescale 1ns/1ps
module atm_rx_port
  import atm_rx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_mode,
  input  logic [BYTE_W-1:0] phy_data,
  input  logic              phy_soc,
  input  logic              phy_stat,
  output logic              phy_en_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              cell_abort
);
  logic     req, byte_due, stat_ok, space, accept, beat_valid;
  rx_beat_t beat, obeat;

  atm_rx_req #(.CELL_BYTES(CELL_BYTES)) u_req (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode), .phy_stat(phy_stat),
    .space(space), .req(req), .byte_due(byte_due), .stat_ok(stat_ok)
  );

  assign accept   = byte_due && stat_ok;
  assign phy_en_n = !req;

  atm_rx_framer #(.CELL_BYTES(CELL_BYTES)) u_frm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .data(phy_data), .soc(phy_soc),
    .beat_valid(beat_valid), .beat(beat), .abort(cell_abort)
  );

  atm_rx_skid u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(beat_valid), .in_beat(beat),
    .out_ready(out_ready), .out_valid(out_valid), .out_beat(obeat), .space(space)
  );

  assign out_data = obeat.data;
  assign out_sop  = obeat.sop;
  assign out_eop  = obeat.eop;
endmodule

// File: rtl/atm_rx_chk.sv
`timescale 1ns/1ps
module atm_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_en_n,
  input logic       phy_soc,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       cell_abort
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (phy_en_n && !out_valid && !cell_abort)); // R1

  AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop)); // R3

  AST_ABORT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    cell_abort |-> ($past(phy_soc) && !$past(phy_en_n, 2))); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R8

  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> phy_en_n); // R9
endmodule

bind atm_rx_port atm_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_en_n(phy_en_n), .phy_soc(phy_soc),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .cell_abort(cell_abort)
);

// File: tb/sim_atm_rx_port.sv
`timescale 1ns/1ps
module sim_atm_rx_port;
  localparam int CELL = 53;

  typedef struct { logic [7:0] data; logic soc; logic vld; } slot_t;
  typedef struct { logic [7:0] data; logic sop; logic eop; int tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, cell_mode = 1'b0;
  logic [7:0] phy_data = 8'h00;
  logic phy_soc = 1'b0, phy_stat = 1'b0, out_ready = 1'b1;
  logic phy_en_n, out_valid, out_sop, out_eop, cell_abort;
  logic [7:0] out_data;

  atm_rx_port #(.CELL_BYTES(CELL)) u0 (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode), .phy_data(phy_data),
    .phy_soc(phy_soc), .phy_stat(phy_stat), .phy_en_n(phy_en_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .cell_abort(cell_abort)
  );

  always #5 clk = ~clk;

  slot_t slots[$];
  exp_t  expq[$];
  int checks = 0, fails = 0, cycles = 0;
  int err_seen = 0, err_exp = 0, popped = 0;
  logic gnt = 1'b0, gnt_cell = 1'b0, bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic [9:0] prev_beat = '0;

  always @(posedge clk) cycles <= cycles + 1;

  // PHY model, ready driver and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int left;
      slot_t s;
      logic vld;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
      vld = 1'b0;
      phy_soc = 1'b0;
      phy_data = 8'h5A;
      if (gnt) begin
        if (slots.size() > 0) begin
          s = slots.pop_front();
          phy_data = s.data; phy_soc = s.soc; vld = s.vld;
          if (gnt_cell) popped++;
        end else if (gnt_cell) begin
          checks++; fails++;
          $display("FAIL R5: cell grant with no cell offered, got request expected none");
        end
      end
      left = (popped % CELL == 0) ? 0 : CELL - (popped % CELL);
      phy_stat = cell_mode ? (slots.size() > left) : vld;
      #2;
      if (prev_stall) begin
        checks++;
        if (!out_valid || {out_data, out_sop, out_eop} != prev_beat) begin
          fails++;
          $display("FAIL R8: stalled beat changed, got %h expected %h", {out_valid, out_data, out_sop, out_eop}, {1'b1, prev_beat});
        end
      end
      if (out_valid && out_ready) begin
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected beat, got %h expected none", out_data);
        end else begin
          e = expq.pop_front();
          if (out_data !== e.data || out_sop !== e.sop || out_eop !== e.eop) begin
            fails++;
            $display("FAIL R%0d: beat got %h/%b%b expected %h/%b%b", e.tag,
                     out_data, out_sop, out_eop, e.data, e.sop, e.eop);
          end
        end
      end
      if (cell_abort) err_seen++;
      prev_stall = out_valid && !out_ready;
      prev_beat  = {out_data, out_sop, out_eop};
      gnt      = !phy_en_n;
      gnt_cell = !phy_en_n && cell_mode;
    end
  end

  // driver: cell with optional invalid slots (start strobe high, must be ignored)
  task automatic add_cell(int len, logic [7:0] base, int gap, int tag);
    for (int i = 0; i < len; i++) begin
      slots.push_back('{data: base + 8'(i), soc: (i == 0), vld: 1'b1});
      expq.push_back('{data: base + 8'(i), sop: (i == 0), eop: (i == CELL - 1), tag: tag});
      if (gap > 0 && (i % gap) == gap - 1) slots.push_back('{data: 8'hFF, soc: 1'b1, vld: 1'b0});
    end
  endtask

  task automatic add_orphans(int n);
    for (int i = 0; i < n; i++) slots.push_back('{data: 8'hC0 + 8'(i), soc: 1'b0, vld: 1'b1});
  endtask

  task automatic drain(string tag);
    int t = 0;
    while ((slots.size() != 0 || expq.size() != 0) && t < 6000) begin
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    checks++;
    if (slots.size() != 0 || expq.size() != 0) begin
      fails++;
      $display("FAIL %s: stream stuck, got %0d/%0d pending expected 0/0", tag, slots.size(), expq.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checks++; // R1 during reset
    if (phy_en_n !== 1'b1 || out_valid !== 1'b0 || cell_abort !== 1'b0) begin
      fails++; $display("FAIL R1: reset state got %b%b%b expected 100", phy_en_n, out_valid, cell_abort);
    end
    @(negedge clk); rst_n = 1'b1; #2;
    checks++; // R1 first cycle after release
    if (phy_en_n !== 1'b1) begin
      fails++; $display("FAIL R1: enable after release got %b expected 1", phy_en_n);
    end

    // R2/R3: per-byte mode, invalid slots carrying a start strobe
    add_cell(CELL, 8'h10, 0, 3);
    add_cell(CELL, 8'h40, 7, 2);
    drain("R2");
    // R8/R9: random back-pressure
    bp_on = 1'b1;
    add_cell(CELL, 8'h80, 5, 8);
    add_cell(CELL, 8'h20, 0, 9);
    add_cell(CELL, 8'h60, 3, 8);
    drain("R8");
    // R7: orphan bytes before a start
    add_orphans(9);
    add_cell(CELL, 8'hA0, 0, 7);
    drain("R7");
    // R6: truncated cell, then a one-byte cell, each cut off
    add_cell(20, 8'h01, 4, 6);
    add_cell(1, 8'hE0, 0, 6);
    add_cell(CELL, 8'h30, 0, 6);
    err_exp += 2;
    drain("R6");
    checks++;
    if (err_seen != err_exp) begin
      fails++; $display("FAIL R6: abort pulses got %0d expected %0d", err_seen, err_exp);
    end

    // R5: per-cell mode with nothing offered keeps enable high
    @(negedge clk); #3;
    cell_mode = 1'b1; popped = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #3;
      checks++;
      if (phy_en_n !== 1'b1) begin
        fails++; $display("FAIL R5: enable with no cell got %b expected 1", phy_en_n);
      end
    end
    // R4/R5: per-cell transfers, flag drops during the last cell
    add_cell(CELL, 8'h11, 0, 4);
    add_cell(CELL, 8'h55, 0, 4);
    add_cell(CELL, 8'h99, 0, 4);
    drain("R4");
    bp_on = 1'b0;
    add_cell(CELL, 8'h07, 0, 5);
    drain("R5");
    checks++;
    if (popped != 4 * CELL) begin
      fails++; $display("FAIL R4: bytes taken got %0d expected %0d", popped, 4 * CELL);
    end
    checks++;
    if (err_seen != err_exp) begin
      fails++; $display("FAIL R6: stray abort got %0d expected %0d", err_seen, err_exp);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule